// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine with Raw and Standard Conventions

The engine folds one byte per clock into a 32-bit cyclic redundancy register built on the generator 0x04C11DB7. The x^32 term is implied, so the full divisor is 0x104C11DB7. A message is framed by a `start_i` pulse and a `finish_i` pulse. Bytes marked with `data_valid_i` between the two are absorbed. One cycle after finish, the final value appears on `result_o` and `done_o` is high for that single cycle.

Two conventions are selectable per message through `mode_i`, which is latched on the start pulse:

- **Raw mode** gives the plain polynomial long-division remainder of the message followed by 32 zero bits.
- **Standard mode** gives the common checksum variant. The register is preset to all ones, bits are consumed least significant first, and the output is bit-reversed and inverted.

Comparing the two modes on the same data shows that a one-bit change in the message spreads across the whole checksum, rather than nudging it by one.

Top module: `crc32_byte_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result_o` becomes 0x00000000 and `done_o` becomes 0.
- R2: With `mode_i`=0 at start (raw mode), the register starts at zero. Each byte is XORed into register bits 31..24, followed by eight left shifts. Each shift that moves a 1 out of bit 31 XORs in 0x04C11DB7. The result is the register unmodified. Examples: byte 0x01 gives 0x04C11DB7, and byte 0x00 gives 0x00000000.
- R3: With `mode_i`=1 at start (standard mode), the register is preset to 0xFFFFFFFF and each byte is consumed bit 0 first. The result is the register bit-reversed and XORed with 0xFFFFFFFF. Examples: byte 0x00 gives 0xD202EF8D, byte 0x01 gives 0xA505DF1B, and ASCII "123456789" gives 0xCBF43926.
- R4: Any number of bytes may be given, one per cycle with `data_valid_i` high, back to back or with idle cycles between them. `data_i` is ignored while `data_valid_i` is low.
- R5: A `finish_i` pulse (without start) updates `result_o` on the next clock edge and raises `done_o` for exactly that one cycle. A byte presented with `data_valid_i` in the finish cycle is included in the result.
- R6: `result_o` keeps its value in every cycle that does not follow a finish.
- R7: The mode is sampled only on the start pulse. Changing `mode_i` during a message has no effect on its result.
- R8: `start_i` has priority. A byte or finish given in the start cycle is ignored, and `done_o` stays low on the next cycle.
- R9: A message with no bytes (start, then finish) gives 0x00000000 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new message; latches the mode and presets the register |
| mode_i | input | 1 | 0 = raw division remainder, 1 = standard reflected/inverted checksum |
| data_valid_i | input | 1 | Marks `data_i` as a message byte this cycle |
| data_i | input | 8 | Message byte |
| finish_i | input | 1 | End the message and publish the result |
| result_o | output | 32 | Final checksum of the last finished message |
| done_o | output | 1 | One-cycle pulse, one cycle after finish |

## Verification
The running register is not visible at the ports. A corrupted register, a wrong preset or a byte taken in the wrong bit order therefore shows up only at the next finish. It then appears as a result that differs in many bits, exactly one cycle after the finish pulse. A wrongly latched mode shows up the same way, as a result that is neither inverted nor mirrored correctly. A wrong control path is visible on the very next clock: `done_o` fires when it should not, or `result_o` moves outside a done cycle. The bench therefore compares both outputs on every cycle against a model that keeps the whole message and recomputes the checksum bit by bit at each finish.

// File: rtl/crc32_pkg.sv
// Shared definitions for the byte-serial CRC-32 engine.
// Assumes a non-reflected, MSB-first register as the common datapath form.
package crc32_pkg;

    // Message convention selected on the start pulse
    typedef enum logic {
        CRC_MODE_RAW = 1'b0,
        CRC_MODE_STD = 1'b1
    } crc_mode_e;

    localparam int unsigned CRC_DEFAULT_W    = 32;
    localparam int unsigned CRC_DEFAULT_DW   = 8;
    localparam logic [31:0] CRC_DEFAULT_POLY = 32'h04C11DB7;

endpackage

// File: rtl/crc32_bit_mirror.sv
// Reverses the bit order of a word: output bit i takes input bit W-1-i.
// Pure wiring, no logic; used for input byte and output word reflection.
module crc32_bit_mirror #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);

    // One wire per bit position, crossing the word end to end
    for (genvar b = 0; b < W; b++) begin : g_mirror
        assign vec_o[b] = vec_i[W-1-b];
    end

endmodule

// File: rtl/crc32_byte_step.sv
// Folds one DATA_W-bit symbol into a CRC_W-bit MSB-first register.
// The symbol is XORed into the top bits, then DATA_W shift/reduce stages
// follow, unrolled as a combinational chain. Assumes DATA_W <= CRC_W.
module crc32_byte_step #(
    parameter int unsigned CRC_W  = 32,
    parameter int unsigned DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] sym_i,
    output logic [CRC_W-1:0]  crc_o
);

    localparam int unsigned PAD_W = CRC_W - DATA_W;

    logic [CRC_W-1:0] stage [DATA_W+1];

    // Merge the symbol into the most significant end of the register
    assign stage[0] = crc_i ^ {sym_i, {PAD_W{1'b0}}};

    // One left shift per symbol bit, reducing by the generator on carry-out
    for (genvar k = 0; k < DATA_W; k++) begin : g_shift
        assign stage[k+1] = stage[k][CRC_W-1]
                          ? ({stage[k][CRC_W-2:0], 1'b0} ^ POLY)
                          :  {stage[k][CRC_W-2:0], 1'b0};
    end

    assign crc_o = stage[DATA_W];

endmodule

// File: rtl/crc32_finalize.sv
// Turns the internal register into the published checksum.
// Raw mode passes the register through. Standard mode mirrors it and
// inverts it with XOR_OUT. Assumes the register is held MSB-first.
module crc32_finalize #(
    parameter int unsigned CRC_W = 32,
    parameter logic [CRC_W-1:0] XOR_OUT = '1
) (
    input  crc32_pkg::crc_mode_e mode_i,
    input  logic [CRC_W-1:0]     crc_i,
    output logic [CRC_W-1:0]     value_o
);
    import crc32_pkg::*;

    logic [CRC_W-1:0] crc_mirrored;

    crc32_bit_mirror #(.W(CRC_W)) i_out_mirror (
        .vec_i (crc_i),
        .vec_o (crc_mirrored)
    );

    // Select raw remainder or reflected, inverted checksum
    always_comb begin
        if (mode_i == CRC_MODE_STD) value_o = crc_mirrored ^ XOR_OUT;
        else                        value_o = crc_i;
    end

endmodule

// File: rtl/crc32_byte_engine.sv
// Byte-serial CRC engine with two conventions sharing one MSB-first datapath.
// Standard mode is realised by mirroring each input byte, presetting to
// PRESET_STD, and mirroring/inverting the output. Assumes start, finish and
// valid are single-cycle qualifiers sampled on the rising clock edge.
module crc32_byte_engine #(
    parameter int unsigned CRC_W  = crc32_pkg::CRC_DEFAULT_W,
    parameter int unsigned DATA_W = crc32_pkg::CRC_DEFAULT_DW,
    parameter logic [CRC_W-1:0] POLY       = crc32_pkg::CRC_DEFAULT_POLY,
    parameter logic [CRC_W-1:0] PRESET_STD = '1,
    parameter logic [CRC_W-1:0] XOR_OUT    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              finish_i,
    output logic [CRC_W-1:0]  result_o,
    output logic              done_o
);
    import crc32_pkg::*;

    localparam logic [CRC_W-1:0] PRESET_RAW = '0;

    crc_mode_e         mode_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_stepped;
    logic [CRC_W-1:0]  crc_next;
    logic [CRC_W-1:0]  final_value;
    logic [DATA_W-1:0] data_mirrored;
    logic [DATA_W-1:0] data_oriented;

    crc32_bit_mirror #(.W(DATA_W)) i_in_mirror (
        .vec_i (data_i),
        .vec_o (data_mirrored)
    );

    // Standard mode consumes bit 0 first, so feed the mirrored byte
    always_comb begin
        if (mode_q == CRC_MODE_STD) data_oriented = data_mirrored;
        else                        data_oriented = data_i;
    end

    crc32_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) i_step (
        .crc_i (crc_q),
        .sym_i (data_oriented),
        .crc_o (crc_stepped)
    );

    // Absorb the byte only when it is marked valid
    always_comb begin
        crc_next = data_valid_i ? crc_stepped : crc_q;
    end

    crc32_finalize #(.CRC_W(CRC_W), .XOR_OUT(XOR_OUT)) i_final (
        .mode_i  (mode_q),
        .crc_i   (crc_next),
        .value_o (final_value)
    );

    // Register, mode latch, published result and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q    <= PRESET_RAW;
            mode_q   <= CRC_MODE_RAW;
            result_o <= '0;
            done_o   <= 1'b0;
        end else if (start_i) begin
            mode_q <= crc_mode_e'(mode_i);
            crc_q  <= mode_i ? PRESET_STD : PRESET_RAW;
            done_o <= 1'b0;
        end else begin
            crc_q  <= crc_next;
            done_o <= finish_i;
            if (finish_i) result_o <= final_value;
        end
    end

endmodule

// File: rtl/crc32_byte_engine_checker.sv
// Temporal properties of the engine's control behaviour, bound to the top.
// Sees the ports plus the latched mode register.
module crc32_byte_engine_checker #(
    parameter int unsigned CRC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             finish_i,
    input logic [CRC_W-1:0] result_o,
    input logic             done_o,
    input logic             mode_q
);

    // R1: reset clears the outputs on the next edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !done_o));

    // R5: an accepted finish produces done on the next cycle
    a_r5_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && !start_i) |=> done_o);

    // R5: no done without an accepted finish
    a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(finish_i && !start_i) |=> !done_o);

    // R6: result only moves after an accepted finish
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish_i || start_i) |=> $stable(result_o));

    // R7: latched mode changes only on start
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(mode_q));

    // R8: a finish in the start cycle is dropped
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

endmodule

bind crc32_byte_engine crc32_byte_engine_checker #(.CRC_W(CRC_W)) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .finish_i (finish_i),
    .result_o (result_o),
    .done_o   (done_o),
    .mode_q   (mode_q)
);

// File: tb/test_crc32_byte_engine.sv
// Self-checking bench: a behavioural model keeps the message bytes in a queue
// and recomputes the checksum bit by bit at each finish; outputs are compared
// on every falling edge, plus named checks on known vectors.
module test_crc32_byte_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        data_valid_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic        finish_i = 1'b0;
    logic [31:0] result_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    crc32_byte_engine i_crc32_byte_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .data_valid_i (data_valid_i),
        .data_i       (data_i),
        .finish_i     (finish_i),
        .result_o     (result_o),
        .done_o       (done_o)
    );

    // Bitwise reference: raw = long division of message||32 zeros,
    // standard = right-shifting reflected form with inverted preset/output
    function automatic logic [31:0] ref_crc(input logic md, input logic [7:0] q[$]);
        logic [31:0] r;
        logic        top;
        if (md) begin
            r = 32'hFFFFFFFF;
            foreach (q[i]) begin
                r = r ^ {24'h0, q[i]};
                for (int b = 0; b < 8; b++)
                    r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
            end
            return ~r;
        end
        r = 32'h0;
        for (int i = 0; i < q.size() + 4; i++) begin
            logic [7:0] byt;
            byt = (i < q.size()) ? q[i] : 8'h00;
            for (int b = 7; b >= 0; b--) begin
                top = r[31];
                r = {r[30:0], byt[b]};
                if (top) r = r ^ 32'h04C11DB7;
            end
        end
        return r;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model of the expected outputs
    logic [7:0]  m_q[$];
    logic        m_mode = 1'b0;
    logic [31:0] exp_res = 32'h0;
    logic        exp_done = 1'b0;
    bit          live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_mode = 1'b0;
            exp_res = 32'h0;
            exp_done = 1'b0;
        end else if (start_i) begin
            m_q.delete();
            m_mode = mode_i;
            exp_done = 1'b0;
        end else begin
            if (data_valid_i) m_q.push_back(data_i);
            exp_done = finish_i;
            if (finish_i) exp_res = ref_crc(m_mode, m_q);
        end
        live = 1'b1;
    end

    // Per-cycle comparison (R1 R5 R6 and the checksum of R2 R3 R4)
    always @(negedge clk) begin
        if (live && !finished) begin
            check32("R5 done_o per cycle", {31'h0, done_o}, {31'h0, exp_done});
            check32("R6 result_o per cycle", result_o, exp_res);
        end
    end

    // Frame a message; returns at the negedge where the result is visible
    task automatic send_msg(input logic md, input logic [7:0] msg[$], input int gap_max,
                            input bit fin_last, input bit wobble);
        @(negedge clk);
        start_i = 1'b1; mode_i = md; data_valid_i = 1'b0; finish_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        foreach (msg[i]) begin
            int gaps;
            gaps = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
            repeat (gaps) begin
                data_valid_i = 1'b0;
                data_i = 8'($urandom);
                if (wobble) mode_i = 1'($urandom);
                @(negedge clk);
            end
            data_valid_i = 1'b1;
            data_i = msg[i];
            if (wobble) mode_i = ~md;
            if (fin_last && i == msg.size() - 1) finish_i = 1'b1;
            @(negedge clk);
            data_valid_i = 1'b0;
            data_i = 8'($urandom);
            finish_i = 1'b0;
        end
        if (!fin_last || msg.size() == 0) begin
            finish_i = 1'b1;
            @(negedge clk);
            finish_i = 1'b0;
        end
        mode_i = md;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 stream did not complete actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] msg[$];

        // R1: reset state
        repeat (3) @(negedge clk);
        check32("R1 result_o in reset", result_o, 32'h0);
        check32("R1 done_o in reset", {31'h0, done_o}, 32'h0);
        rst_n = 1'b1;

        // R2: raw mode single bytes
        msg = '{8'h01};
        send_msg(1'b0, msg, 0, 1'b0, 1'b0);
        check32("R2 raw 0x01", result_o, 32'h04C11DB7);
        check32("R5 done after finish", {31'h0, done_o}, 32'h1);
        @(negedge clk);
        check32("R5 done single cycle", {31'h0, done_o}, 32'h0);
        msg = '{8'h00};
        send_msg(1'b0, msg, 0, 1'b1, 1'b0);
        check32("R2 raw 0x00", result_o, 32'h0);

        // R3: standard mode vectors
        msg = '{8'h00};
        send_msg(1'b1, msg, 0, 1'b0, 1'b0);
        check32("R3 std 0x00", result_o, 32'hD202EF8D);
        msg = '{8'h01};
        send_msg(1'b1, msg, 0, 1'b1, 1'b0);
        check32("R3 std 0x01 with finish on last byte R5", result_o, 32'hA505DF1B);
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send_msg(1'b1, msg, 2, 1'b0, 1'b0);
        check32("R3 std 123456789 with gaps R4", result_o, 32'hCBF43926);

        // R6: result holds across idle cycles
        repeat (5) @(negedge clk);
        check32("R6 result hold", result_o, 32'hCBF43926);

        // R7: mode toggled mid-message has no effect
        send_msg(1'b1, msg, 1, 1'b0, 1'b1);
        check32("R7 mode wobble std", result_o, 32'hCBF43926);
        msg = '{8'h01};
        send_msg(1'b0, msg, 2, 1'b1, 1'b1);
        check32("R7 mode wobble raw", result_o, 32'h04C11DB7);

        // R9: empty messages
        msg.delete();
        send_msg(1'b1, msg, 0, 1'b0, 1'b0);
        check32("R9 empty std", result_o, 32'h0);
        send_msg(1'b0, msg, 0, 1'b0, 1'b0);
        check32("R9 empty raw", result_o, 32'h0);

        // R8: byte and finish in the start cycle are ignored
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0; data_valid_i = 1'b1; data_i = 8'hAA; finish_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; data_valid_i = 1'b0; finish_i = 1'b0;
        check32("R8 no done after start", {31'h0, done_o}, 32'h0);
        data_valid_i = 1'b1; data_i = 8'h01; finish_i = 1'b1;
        @(negedge clk);
        data_valid_i = 1'b0; finish_i = 1'b0;
        check32("R8 start-cycle byte dropped", result_o, 32'h04C11DB7);

        // R4: random messages of 1..64 bytes in both modes
        for (int n = 0; n < 40; n++) begin
            int len;
            logic md;
            len = 1 + int'($urandom % 64);
            md = 1'(n % 2);
            msg.delete();
            for (int j = 0; j < len; j++) msg.push_back(8'($urandom));
            send_msg(md, msg, n % 3, 1'(n / 2 % 2), n % 4 == 3);
            check32("R4 random message", result_o, ref_crc(md, msg));
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule